// File: doc/BRIEF.md
# Sync-Driven Capture Window Cropper

The block sits on a pixel stream that arrives with vertical sync, horizontal sync and field-ID signals. It counts samples along each line and lines within each field. It raises a write-enable for the samples that fall inside a programmed rectangle. A memory writer downstream then stores only those samples. The block also emits a one-cycle interrupt pulse when the line counter reaches a programmed line, for example the middle of the image. It latches the field ID at each vertical sync so that software can tell which field is being captured.

A simple synchronous write port programs the configuration. It sets the window start and size, the interrupt line, the active level of each sync input, progressive or interlaced operation, and two enables. Sizes are written as count minus one. The line that opens each field carries no image data, so line numbers used for the window start at that line. A start of 1 selects the first real line. Horizontal values are written in samples. For two-sample-per-pixel formats, software programs twice the pixel values. In interlaced mode the vertical values are written per frame and the block halves them for each field.

Top module: `capture_window_crop`

## Requirements
- R1: While reset is high and in the cycle after it, `pix_we`, `line_irq`, `fid_status` and `pix_out` are 0.
- R2: The sample counter is 0 in the cycle where an active HD edge is seen (inactive to active) and rises by one each later cycle. Samples from hstart to hstart+hcount_m1 inclusive are inside the window horizontally.
- R3: The line counter is 0 in the cycle of an active VD edge and rises by one on each active HD edge. When both edges fall in one cycle, the line counter is 0. In progressive mode, lines vstart to vstart+vcount_m1 are inside the window.
- R4: In interlaced mode (control bit 5 set), the field window starts at line 1+((vstart−1)>>1) and ends ((vcount_m1+1)>>1)−1 lines later. When vcount_m1 is 0 the window is one line. When vstart is 0 the start is line 0.
- R5: Control bits 2, 3 and 4 make the VD, HD and field-ID inputs active low when set. When clear, those inputs are active high.
- R6: `pix_out` and `pix_we` belong to the sample presented one cycle earlier on `pix_in`.
- R7: `pix_we` is high only when control bit 0 (sync enable) and control bit 1 (memory write enable) are both set.
- R8: `line_irq` is a one-cycle pulse, one cycle after a cycle with an active HD or VD edge in which the line counter equals irq_line. It needs sync enable and does not depend on memory write enable.
- R9: `fid_status` takes the active-level-corrected field ID one cycle after each active VD edge. It holds between VD edges.
- R10: After reset, no `pix_we` and no `line_irq` occur until the first active VD edge.
- R11: The write-port addresses are 0 control, 1 hstart, 2 hcount_m1, 3 vstart, 4 vcount_m1, 5 irq_line. A write takes effect from the next cycle. Writes to addresses 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| vd_in | input | 1 | Vertical sync |
| hd_in | input | 1 | Horizontal sync |
| fid_in | input | 1 | Field ID |
| pix_in | input | PIX_W | Input sample |
| pix_out | output | PIX_W | Sample delayed by one cycle |
| pix_we | output | 1 | Write-enable for the delayed sample |
| line_irq | output | 1 | Programmed-line interrupt pulse |
| fid_status | output | 1 | Field ID latched at the last VD edge |

## Verification
Two events can land in the same cycle: a vertical sync edge and a horizontal sync edge. The line counter must then be 0 rather than advancing, and an interrupt programmed for line 0 must fire from that one cycle. The bench drives frames whose sync pulses start together. It also drives a frame whose VD edge falls in the middle of a line. In both cases it compares every cycle's write-enable, interrupt and field status against expectations it derives from the sync edges it produced.

// File: rtl/crop_pkg.sv
package crop_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_HSTART = 3'd1,
        A_HCNT   = 3'd2,
        A_VSTART = 3'd3,
        A_VCNT   = 3'd4,
        A_IRQLN  = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic fid_neg;
        logic hd_neg;
        logic vd_neg;
    } pol_t;

    typedef struct packed {
        logic             interlaced;
        logic             mem_en;
        logic             sync_en;
        logic [REG_W-1:0] hstart;
        logic [REG_W-1:0] hcnt_m1;
        logic [REG_W-1:0] vstart;
        logic [REG_W-1:0] vcnt_m1;
        logic [REG_W-1:0] irq_line;
    } win_cfg_t;

    // first line of the field window
    function automatic logic [REG_W-1:0] field_start(input logic [REG_W-1:0] vs,
                                                     input logic il);
        if (!il || vs == '0) return vs;
        return REG_W'(1) + ((vs - REG_W'(1)) >> 1);
    endfunction

    // field window length minus one
    function automatic logic [REG_W-1:0] field_cnt_m1(input logic [REG_W-1:0] c,
                                                      input logic il);
        logic [REG_W:0] t;
        if (!il) return c;
        if (c == '0) return '0;
        t = {1'b0, c} + (REG_W+1)'(1);
        return REG_W'((t >> 1) - (REG_W+1)'(1));
    endfunction

endpackage

// File: rtl/crop_cfg_regs.sv
module crop_cfg_regs
    import crop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output pol_t              pol,
    output win_cfg_t          wcfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pol  <= '0;
            wcfg <= '0;
        end else if (we) begin
            case (reg_addr_e'(addr))
                A_CTRL: begin
                    wcfg.sync_en    <= wdata[0];
                    wcfg.mem_en     <= wdata[1];
                    pol.vd_neg      <= wdata[2];
                    pol.hd_neg      <= wdata[3];
                    pol.fid_neg     <= wdata[4];
                    wcfg.interlaced <= wdata[5];
                end
                A_HSTART: wcfg.hstart   <= wdata;
                A_HCNT:   wcfg.hcnt_m1  <= wdata;
                A_VSTART: wcfg.vstart   <= wdata;
                A_VCNT:   wcfg.vcnt_m1  <= wdata;
                A_IRQLN:  wcfg.irq_line <= wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/crop_sync_edge.sv
module crop_sync_edge #(
    parameter int NSYNC = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSYNC-1:0] raw,
    input  logic [NSYNC-1:0] neg,
    output logic [NSYNC-1:0] act,
    output logic [NSYNC-1:0] edge_o
);

    logic [NSYNC-1:0] prev_q;

    for (genvar i = 0; i < NSYNC; i++) begin : g_sync
        assign act[i]    = raw[i] ^ neg[i];
        assign edge_o[i] = act[i] & ~prev_q[i];

        always_ff @(posedge clk) begin
            if (rst) prev_q[i] <= 1'b0;
            else     prev_q[i] <= act[i];
        end

        // R5: an edge is only seen after the corrected level was inactive
        assert_edge_once_R5: assert property (@(posedge clk) disable iff (rst)
            edge_o[i] |=> !edge_o[i]);
    end

endmodule

// File: rtl/crop_window_ctr.sv
module crop_window_ctr
    import crop_pkg::*;
#(
    parameter int H_W   = 12,
    parameter int V_W   = 11,
    parameter int PIX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  win_cfg_t         wcfg,
    input  logic             hd_edge,
    input  logic             vd_edge,
    input  logic             fid_act,
    input  logic [PIX_W-1:0] pix_in,
    output logic [PIX_W-1:0] pix_out,
    output logic             pix_we,
    output logic             line_irq,
    output logic             fid_status
);

    localparam logic [H_W-1:0] H_MAX = {H_W{1'b1}};
    localparam logic [V_W-1:0] V_MAX = {V_W{1'b1}};
    localparam int EXT_W = REG_W + 1;

    logic [H_W-1:0]   h_q, h_now;
    logic [V_W-1:0]   v_q, v_now;
    logic [EXT_W-1:0] h_ext, v_ext, h_end, v_end, v_beg;
    logic [REG_W-1:0] eff_vs, eff_cm1;
    logic             h_in, v_in, win, irq_hit;

    always_comb begin
        if (hd_edge)             h_now = '0;
        else if (h_q != H_MAX)   h_now = h_q + H_W'(1);
        else                     h_now = h_q;

        if (vd_edge)                    v_now = '0;
        else if (hd_edge && v_q != V_MAX) v_now = v_q + V_W'(1);
        else                            v_now = v_q;
    end

    assign eff_vs  = field_start(wcfg.vstart, wcfg.interlaced);
    assign eff_cm1 = field_cnt_m1(wcfg.vcnt_m1, wcfg.interlaced);

    assign h_ext = EXT_W'(h_now);
    assign v_ext = EXT_W'(v_now);
    assign h_end = EXT_W'(wcfg.hstart) + EXT_W'(wcfg.hcnt_m1);
    assign v_beg = EXT_W'(eff_vs);
    assign v_end = v_beg + EXT_W'(eff_cm1);

    assign h_in = (h_now != H_MAX) && (h_ext >= EXT_W'(wcfg.hstart)) && (h_ext <= h_end);
    assign v_in = (v_now != V_MAX) && (v_ext >= v_beg) && (v_ext <= v_end);
    assign win  = wcfg.sync_en & wcfg.mem_en & h_in & v_in;

    assign irq_hit = wcfg.sync_en & (hd_edge | vd_edge) & (v_now != V_MAX) &
                     (v_ext == EXT_W'(wcfg.irq_line));

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q        <= H_MAX;
            v_q        <= V_MAX;
            pix_we     <= 1'b0;
            line_irq   <= 1'b0;
            fid_status <= 1'b0;
            pix_out    <= '0;
        end else begin
            h_q      <= h_now;
            v_q      <= v_now;
            pix_we   <= win;
            line_irq <= irq_hit;
            pix_out  <= pix_in;
            if (vd_edge) fid_status <= fid_act;
        end
    end

    // R7: a write-enable needs both enables in the sample's cycle
    assert_we_gated_R7: assert property (@(posedge clk) disable iff (rst)
        pix_we |-> $past(wcfg.sync_en && wcfg.mem_en));

    // R2: the sample counter restarts on the HD edge
    assert_hcnt_zero_R2: assert property (@(posedge clk) disable iff (rst)
        hd_edge |=> (h_q == '0));

    // R3: the line counter restarts on the VD edge, also when HD coincides
    assert_vcnt_zero_R3: assert property (@(posedge clk) disable iff (rst)
        vd_edge |=> (v_q == '0));

    // R8: interrupt requires sync enable and is a single-cycle pulse
    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (rst)
        line_irq |-> $past(wcfg.sync_en));
    assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        line_irq |=> !line_irq);

    // R9: field status only moves after a VD edge
    assert_fid_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !vd_edge |=> $stable(fid_status));

endmodule

// File: rtl/capture_window_crop.sv
module capture_window_crop
    import crop_pkg::*;
#(
    parameter int H_W   = 12,
    parameter int V_W   = 11,
    parameter int PIX_W = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [REG_W-1:0]     cfg_wdata,
    input  logic                 vd_in,
    input  logic                 hd_in,
    input  logic                 fid_in,
    input  logic [PIX_W-1:0]     pix_in,
    output logic [PIX_W-1:0]     pix_out,
    output logic                 pix_we,
    output logic                 line_irq,
    output logic                 fid_status
);

    pol_t     pol;
    win_cfg_t wcfg;
    logic [2:0] act, edg;

    crop_cfg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .pol   (pol),
        .wcfg  (wcfg)
    );

    // index 0 VD, 1 HD, 2 field ID
    crop_sync_edge #(.NSYNC(3)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    ({fid_in, hd_in, vd_in}),
        .neg    ({pol.fid_neg, pol.hd_neg, pol.vd_neg}),
        .act    (act),
        .edge_o (edg)
    );

    crop_window_ctr #(.H_W(H_W), .V_W(V_W), .PIX_W(PIX_W)) u_ctr (
        .clk        (clk),
        .rst        (rst),
        .wcfg       (wcfg),
        .hd_edge    (edg[1]),
        .vd_edge    (edg[0]),
        .fid_act    (act[2]),
        .pix_in     (pix_in),
        .pix_out    (pix_out),
        .pix_we     (pix_we),
        .line_irq   (line_irq),
        .fid_status (fid_status)
    );

endmodule

// File: tb/capture_window_crop_bench.sv
module capture_window_crop_bench;

    localparam int PIX_W = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic vd_in = 1'b0, hd_in = 1'b0, fid_in = 1'b0;
    logic [PIX_W-1:0] pix_in = '0;
    logic [PIX_W-1:0] pix_out;
    logic pix_we, line_irq, fid_status;

    always #4 clk = ~clk;

    capture_window_crop u_capture_window_crop (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .vd_in(vd_in), .hd_in(hd_in), .fid_in(fid_in),
        .pix_in(pix_in), .pix_out(pix_out), .pix_we(pix_we),
        .line_irq(line_irq), .fid_status(fid_status)
    );

    typedef struct {
        logic we;
        logic irq;
        logic fid;
        logic [PIX_W-1:0] pix;
        string tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;

    // bench copy of the programmed settings
    bit sync_en, mem_en, vneg, hneg, fneg, ilace;
    int hs, hc, vs, vc, irql;
    // bench view of the stream
    bit prev_h, prev_v, exp_fid;
    int samp, line;
    int pix_ctr = 0;
    string cur_tag;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // monitor: one expectation per cycle, one cycle behind the driver
    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, "pix_we", int'(pix_we), int'(e.we));
            chk("R8", "line_irq", int'(line_irq), int'(e.irq));
            chk("R9", "fid_status", int'(fid_status), int'(e.fid));
            chk("R6", "pix_out", int'(pix_out), int'(e.pix));
        end
    end

    function automatic int eff_start();
        if (!ilace || vs == 0) return vs;
        return 1 + ((vs - 1) >> 1);
    endfunction

    function automatic int eff_cm1();
        if (!ilace) return vc;
        if (vc == 0) return 0;
        return ((vc + 1) >> 1) - 1;
    endfunction

    task automatic wr(input int a, input int d);
        @(negedge clk); #1;
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
        @(negedge clk); #1;
        cfg_we = 1'b0;
        if (a == 0) begin
            sync_en = d[0]; mem_en = d[1]; vneg = d[2];
            hneg = d[3]; fneg = d[4]; ilace = d[5];
        end else if (a == 1) hs = d;
        else if (a == 2) hc = d;
        else if (a == 3) vs = d;
        else if (a == 4) vc = d;
        else if (a == 5) irql = d;
        vd_in = vneg; hd_in = hneg; fid_in = fneg;
    endtask

    // drive one cycle of active levels, then queue its expected outputs
    task automatic drive(input bit ha, input bit va, input bit fa);
        bit he, ve;
        exp_t e;
        int es, ec;
        @(negedge clk); #1;
        hd_in = ha ^ hneg; vd_in = va ^ vneg; fid_in = fa ^ fneg;
        pix_ctr++;
        pix_in = PIX_W'(pix_ctr * 37);
        he = ha && !prev_h; ve = va && !prev_v;
        prev_h = ha; prev_v = va;
        if (he) samp = 0; else samp++;
        if (ve) line = 0; else if (he && line >= 0) line++;
        if (ve) exp_fid = fa;
        es = eff_start(); ec = eff_cm1();
        e.we  = sync_en && mem_en && line >= 0 && samp >= hs && samp <= hs + hc &&
                line >= es && line <= es + ec;
        e.irq = sync_en && (he || ve) && line >= 0 && line == irql;
        e.fid = exp_fid;
        e.pix = pix_in;
        e.tag = cur_tag;
        q.push_back(e);
    endtask

    // vd_off < 0: no VD in this frame; otherwise VD rises at that sample of line 0
    task automatic frame(input int nlines, input int spl, input int vd_off, input bit fa);
        for (int l = 0; l < nlines; l++) begin
            for (int s = 0; s < spl; s++) begin
                bit va;
                va = (vd_off >= 0) && (l == 0) && (s >= vd_off) && (s < vd_off + 3);
                drive(s < 2, va, fa);
            end
        end
        repeat (2) drive(1'b0, 1'b0, fa);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        samp = 1 << 20; line = -1;
        repeat (3) @(negedge clk);
        chk("R1", "pix_we in reset", int'(pix_we), 0);
        chk("R1", "line_irq in reset", int'(line_irq), 0);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1", "pix_we after reset", int'(pix_we), 0);
        chk("R1", "fid_status after reset", int'(fid_status), 0);
        chk("R1", "pix_out after reset", int'(pix_out), 0);

        wr(1, 3); wr(2, 4); wr(3, 2); wr(4, 2); wr(5, 0);
        wr(0, 16'h0003);

        // no VD yet: nothing may be written, even with irq at line 0
        cur_tag = "R10";
        frame(4, 12, -1, 1'b0);

        // progressive, HD and VD edges together
        cur_tag = "R3";
        wr(5, 3);
        frame(7, 12, 0, 1'b0);

        // full-line window starting at the HD edge sample
        cur_tag = "R2";
        wr(1, 0); wr(2, 11);
        frame(6, 12, 0, 1'b1);

        // VD edge inside a line
        cur_tag = "R3";
        wr(1, 2); wr(2, 5);
        frame(7, 12, 5, 1'b0);

        // writes to unused addresses leave the window alone
        cur_tag = "R11";
        wr(6, 16'hFFFF); wr(7, 16'h0000);
        frame(6, 12, 0, 1'b0);

        // all inputs active low
        cur_tag = "R5";
        wr(0, 16'h001F);
        frame(7, 12, 0, 1'b1);
        frame(6, 12, 0, 1'b0);

        // interlaced: frame values 5/5 give field lines 3..5
        cur_tag = "R4";
        wr(0, 16'h0023); wr(3, 5); wr(4, 5); wr(5, 4);
        frame(8, 12, 0, 1'b0);
        frame(8, 12, 0, 1'b1);
        wr(4, 0);
        frame(6, 12, 0, 1'b0);

        // memory write disabled: no writes, interrupt still fires
        cur_tag = "R7";
        wr(0, 16'h0001); wr(3, 2); wr(4, 2); wr(5, 2);
        frame(6, 12, 0, 1'b1);
        // sync disabled: neither writes nor interrupt
        wr(0, 16'h0002);
        frame(6, 12, 0, 1'b0);

        // interrupt at line 0 from coincident HD and VD edges
        cur_tag = "R8";
        wr(0, 16'h0003); wr(5, 0);
        frame(5, 12, 0, 1'b1);

        @(negedge clk); @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule